// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns bytes written by a processor into asynchronous serial characters. A write places a byte in a one-deep holding register. When the transmit shifter reaches a character boundary, the pending byte moves into the shifter, provided clear-to-send is asserted or loop mode is on. Each character is sent as follows:

- a start bit at space (logic 0);
- 5 to 8 data bits, least significant bit first;
- an optional even or odd parity bit;
- one or two stop bits at mark (logic 1).

Every bit lasts sixteen pulses of a 16x baud enable that is supplied from outside. A status output reports that the holding register is empty. Software watches it to know when the next byte may be written.

The clear-to-send input is active low. It only holds off the start of a new character. A character that has already started always runs to the end of its last stop bit. Loop mode routes the serial stream to a separate loopback output for a neighbouring receiver. In loop mode the external line stays at mark and clear-to-send is ignored. Character length, parity and stop count are static controls, and they are captured when each character starts.

Top module: `uart_tx_core`

## Requirements
- R1: While rst_ni is low, txd_o and loop_txd_o are 1 and hold_empty_o is 1.
- R2: A character starts with one space bit. Data follows LSB first. Each bit lasts exactly 16 baud_en_i pulses, and the line idles at mark.
- R3: char_len_i selects the data bit count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Written bits above that count are ignored and never appear on the line.
- R4: With parity_en_i at 1, one parity bit follows the data. With parity_odd_i at 0 the count of ones over data and parity is even, and with it at 1 that count is odd. With parity_en_i at 0 no parity bit is sent.
- R5: stop_two_i at 0 gives one stop bit and at 1 gives two, both at mark.
- R6: A write clears hold_empty_o on the next cycle. hold_empty_o returns to 1 when the byte moves into the shifter.
- R7: While cts_ni is 1 and loop mode is off, no character starts. txd_o stays at mark and hold_empty_o stays 0.
- R8: cts_ni rising during a character does not shorten or alter that character.
- R9: With loop_en_i at 1, txd_o is held at mark, loop_txd_o carries the character, and cts_ni has no effect. With loop_en_i at 0, loop_txd_o is at mark.
- R10: A second write before the pending byte is taken replaces it. Only the last byte is sent.
- R11: If a byte is pending and clear-to-send is asserted when the last stop bit ends, the next start bit begins with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_en_i | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to transmit |
| char_len_i | input | 2 | Data bit count code (0..3 gives 5..8 bits) |
| parity_en_i | input | 1 | Append a parity bit |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| stop_two_i | input | 1 | 1 selects two stop bits |
| loop_en_i | input | 1 | Loop mode |
| cts_ni | input | 1 | Clear to send, active low |
| txd_o | output | 1 | External serial line |
| loop_txd_o | output | 1 | Serial stream toward the loopback receiver |
| hold_empty_o | output | 1 | Holding register is empty |

## Verification
The hardest case to reach is a clear-to-send change that lands in the middle of a character. A second hard case is a byte that arrives exactly as the last stop bit ends, which must produce a back-to-back start with no idle bit. The bench forks a line decoder against a timed release of clear-to-send so the release falls deep inside the data bits. For the back-to-back case, the bench writes the second byte as soon as the empty flag rises and measures how long the decoder waits after the previous stop bit. Random frames cover every combination of length, parity and stop count.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned LEN_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             par_en;
    logic             par_odd;
    logic             stop_two;
  } frame_cfg_t;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] hold_data_o,
  output logic              hold_full_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  // write wins over take: a byte written in the take cycle stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (wr_en_i) begin
      data_q <= wr_data_i;
      full_q <= 1'b1;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign hold_data_o = data_q;
  assign hold_full_o = full_q;
endmodule

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic baud_en_i,
  input  logic restart_i,
  input  logic active_i,
  output logic bit_end_o
);
  localparam int unsigned CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bit_end_o = active_i && baud_en_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || bit_end_o) begin
      cnt_q <= '0;
    end else if (active_i && baud_en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_BITS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_en_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              cts_ok_i,
  input  logic              bit_end_i,
  input  frame_cfg_t        cfg_i,
  output logic              load_o,
  output logic              active_o,
  output logic              bit_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic [CNT_W-1:0]  dcnt_q;
  logic              stop_q;

  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] masked;
  logic              par_nxt;
  logic [CNT_W-1:0]  last_idx;
  logic              last_stop;

  // bits above the selected length are dropped at load
  for (genvar g = 0; g < DATA_W; g++) begin : g_keep
    if (g < MIN_BITS) begin : g_fixed
      assign keep[g] = 1'b1;
    end else begin : g_var
      assign keep[g] = ({{(32-LEN_W){1'b0}}, cfg_i.len} > 32'(g - MIN_BITS));
    end
  end

  assign masked    = hold_data_i & keep;
  assign par_nxt   = (^masked) ^ cfg_i.par_odd;
  assign last_idx  = CNT_W'(MIN_BITS - 1) + CNT_W'(cfg_q.len);
  assign last_stop = (state_q == ST_STOP) && bit_end_i && (stop_q == cfg_q.stop_two);
  assign load_o    = baud_en_i && hold_full_i && cts_ok_i &&
                     ((state_q == ST_IDLE) || last_stop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      dcnt_q  <= '0;
      stop_q  <= 1'b0;
    end else if (load_o) begin
      state_q <= ST_START;
      cfg_q   <= cfg_i;
      shreg_q <= masked;
      par_q   <= par_nxt;
      dcnt_q  <= '0;
      stop_q  <= 1'b0;
    end else if (bit_end_i) begin
      unique case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          shreg_q <= shreg_q >> 1;
          if (dcnt_q == last_idx) begin
            state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            dcnt_q <= dcnt_q + 1'b1;
          end
        end
        ST_PAR: state_q <= ST_STOP;
        ST_STOP: begin
          if (stop_q == cfg_q.stop_two) state_q <= ST_IDLE;
          else stop_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: bit_o = 1'b0;
      ST_DATA:  bit_o = shreg_q[0];
      ST_PAR:   bit_o = par_q;
      default:  bit_o = 1'b1;
    endcase
  end

  assign active_o = (state_q != ST_IDLE);
endmodule

// File: rtl/tx_line_out.sv
module tx_line_out (
  input  logic loop_en_i,
  input  logic active_i,
  input  logic bit_i,
  output logic txd_o,
  output logic loop_txd_o
);
  assign txd_o      = (active_i && !loop_en_i) ? bit_i : 1'b1;
  assign loop_txd_o = (active_i && loop_en_i) ? bit_i : 1'b1;
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OVS      = 16,
  parameter int unsigned MIN_BITS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              stop_two_i,
  input  logic              loop_en_i,
  input  logic              cts_ni,
  output logic              txd_o,
  output logic              loop_txd_o,
  output logic              hold_empty_o
);
  logic [DATA_W-1:0] hold_data_s;
  logic              hold_full_s;
  logic              load_s;
  logic              active_s;
  logic              bit_end_s;
  logic              line_bit_s;
  logic              cts_ok_s;
  frame_cfg_t        cfg_s;

  assign cts_ok_s       = loop_en_i || !cts_ni;
  assign cfg_s.len      = char_len_i;
  assign cfg_s.par_en   = parity_en_i;
  assign cfg_s.par_odd  = parity_odd_i;
  assign cfg_s.stop_two = stop_two_i;

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .take_i      (load_s),
    .hold_data_o (hold_data_s),
    .hold_full_o (hold_full_s)
  );

  tx_tick_timer #(.OVS(OVS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .baud_en_i (baud_en_i),
    .restart_i (load_s),
    .active_i  (active_s),
    .bit_end_o (bit_end_s)
  );

  tx_frame_fsm #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .baud_en_i   (baud_en_i),
    .hold_full_i (hold_full_s),
    .hold_data_i (hold_data_s),
    .cts_ok_i    (cts_ok_s),
    .bit_end_i   (bit_end_s),
    .cfg_i       (cfg_s),
    .load_o      (load_s),
    .active_o    (active_s),
    .bit_o       (line_bit_s)
  );

  tx_line_out u_line (
    .loop_en_i  (loop_en_i),
    .active_i   (active_s),
    .bit_i      (line_bit_s),
    .txd_o      (txd_o),
    .loop_txd_o (loop_txd_o)
  );

  assign hold_empty_o = !hold_full_s;
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_en_i,
  input logic wr_en_i,
  input logic loop_en_i,
  input logic cts_ni,
  input logic txd_o,
  input logic loop_txd_o,
  input logic hold_empty_o,
  input logic load_s,
  input logic line_bit_s
);
  AST_LOOP_PIN_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_i |-> txd_o); // R9
  AST_ECHO_IDLE_NO_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |-> loop_txd_o); // R9
  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !hold_empty_o); // R6
  AST_TAKE_SETS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_s && !wr_en_i) |=> hold_empty_o); // R6
  AST_CTS_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_s && !loop_en_i) |-> !cts_ni); // R7
  AST_LINE_HOLDS_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_en_i |=> $stable(line_bit_s)); // R2
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .baud_en_i    (baud_en_i),
  .wr_en_i      (wr_en_i),
  .loop_en_i    (loop_en_i),
  .cts_ni       (cts_ni),
  .txd_o        (txd_o),
  .loop_txd_o   (loop_txd_o),
  .hold_empty_o (hold_empty_o),
  .load_s       (load_s),
  .line_bit_s   (line_bit_s)
);

// File: tb/sim_uart_tx_core.sv
`timescale 1ns/1ps
module sim_uart_tx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       stop_two = 1'b0;
  logic       loop_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd;
  logic       loop_txd;
  logic       hold_empty;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uart_tx_core u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .baud_en_i    (baud_en),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .char_len_i   (char_len),
    .parity_en_i  (par_en),
    .parity_odd_i (par_odd),
    .stop_two_i   (stop_two),
    .loop_en_i    (loop_en),
    .cts_ni       (cts_n),
    .txd_o        (txd),
    .loop_txd_o   (loop_txd),
    .hold_empty_o (hold_empty)
  );

  // 16x enable every 4 clocks
  initial begin
    int bc = 0;
    forever begin
      @(negedge clk);
      bc++;
      baud_en = (bc % 4 == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void build(input logic [7:0] d, input logic [1:0] len, input logic pe,
                                input logic po, input logic s2, output logic [11:0] bits,
                                output int n);
    int nd = 5 + int'(len);
    logic [7:0] m = 8'hFF >> (8 - nd);
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) bits[1+i] = d[i];
    n = 1 + nd;
    if (pe) begin
      bits[n] = (^(d & m)) ^ po;
      n++;
    end
    bits[n] = 1'b1;
    n++;
    if (s2) begin
      bits[n] = 1'b1;
      n++;
    end
  endfunction

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rx(input bit use_loop, input int n, output logic [11:0] got,
                    output int waited, output bit pin_ok);
    got = '1;
    waited = 0;
    pin_ok = 1'b1;
    @(negedge clk);
    while ((use_loop ? loop_txd : txd) !== 1'b0 && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    repeat (32) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) repeat (64) @(negedge clk);
      got[k] = use_loop ? loop_txd : txd;
      if (use_loop && txd !== 1'b1) pin_ok = 1'b0;
    end
  endtask

  task automatic frame_check(input logic [7:0] d, input bit use_loop, input string req);
    logic [11:0] exp, got;
    int n, w;
    bit pin_ok;
    build(d, char_len, par_en, par_odd, stop_two, exp, n);
    rx(use_loop, n, got, w, pin_ok);
    chk(((got ^ exp) & ((12'h1 << n) - 1)) == 0, req, {20'h0, got}, {20'h0, exp});
    if (use_loop) chk(pin_ok, "R9 external pin at mark in loop", {31'h0, pin_ok}, 1);
  endtask

  initial begin
    logic [11:0] exp_b, got_b;
    int nb, wb;
    bit pk;
    bit seen_low;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && loop_txd === 1'b1 && hold_empty === 1'b1, "R1 reset state",
        {29'h0, txd, loop_txd, hold_empty}, 32'h7);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 flag timing
    write_byte(8'hA5);
    chk(hold_empty === 1'b0, "R6 empty cleared by write", {31'h0, hold_empty}, 0);
    repeat (5) @(negedge clk);
    chk(hold_empty === 1'b1, "R6 empty set on transfer", {31'h0, hold_empty}, 1);
    frame_check(8'hA5, 0, "R2 8N1 frame");

    // R3 masking: upper bits must not appear
    char_len = 2'd0;
    write_byte(8'hE0);
    frame_check(8'hE0, 0, "R3 5-bit masks upper bits");

    // random configurations
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d = 8'($urandom);
      char_len = 2'($urandom);
      par_en = 1'($urandom);
      par_odd = 1'($urandom);
      stop_two = 1'($urandom);
      write_byte(d);
      frame_check(d, 0, "R2 R3 R4 R5 random frame");
    end

    // directed parity and two stop bits
    char_len = 2'd3; par_en = 1'b1; par_odd = 1'b1; stop_two = 1'b1;
    write_byte(8'h00);
    frame_check(8'h00, 0, "R4 R5 odd parity two stops");
    par_odd = 1'b0;
    write_byte(8'h07);
    frame_check(8'h07, 0, "R4 even parity");
    par_en = 1'b0; stop_two = 1'b0;
    repeat (80) @(negedge clk);

    // R7 CTS holds off start
    cts_n = 1'b1;
    write_byte(8'h3C);
    seen_low = 1'b0;
    repeat (400) begin
      @(negedge clk);
      if (txd !== 1'b1) seen_low = 1'b1;
    end
    chk(!seen_low, "R7 line at mark while CTS false", {31'h0, seen_low}, 0);
    chk(hold_empty === 1'b0, "R7 byte stays pending", {31'h0, hold_empty}, 0);
    cts_n = 1'b0;
    frame_check(8'h3C, 0, "R7 frame after CTS true");

    // R8 CTS false mid-character
    write_byte(8'h96);
    fork
      frame_check(8'h96, 0, "R8 frame completes after CTS false");
      begin
        repeat (250) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    cts_n = 1'b0;
    repeat (80) @(negedge clk);

    // R9 loop mode ignores CTS
    loop_en = 1'b1; cts_n = 1'b1;
    char_len = 2'd2; par_en = 1'b1;
    write_byte(8'h5B);
    frame_check(8'h5B, 1, "R9 loop stream");
    repeat (80) @(negedge clk);
    loop_en = 1'b0; par_en = 1'b0; char_len = 2'd3;

    // R10 overwrite pending byte
    write_byte(8'h11);
    write_byte(8'hC3);
    chk(hold_empty === 1'b0, "R10 pending after two writes", {31'h0, hold_empty}, 0);
    cts_n = 1'b0;
    frame_check(8'hC3, 0, "R10 last write sent");
    repeat (80) @(negedge clk);

    // R11 back-to-back
    write_byte(8'h81);
    while (hold_empty !== 1'b1) @(negedge clk);
    write_byte(8'h7E);
    frame_check(8'h81, 0, "R11 first of pair");
    build(8'h7E, char_len, par_en, par_odd, stop_two, exp_b, nb);
    rx(0, nb, got_b, wb, pk);
    chk(wb <= 34, "R11 no idle gap", wb, 34);
    chk(((got_b ^ exp_b) & ((12'h1 << nb) - 1)) == 0, "R11 second of pair",
        {20'h0, got_b}, {20'h0, exp_b});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule